// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide addresses on a simple I/O bus. Address 0 is the index/key port and address 1 is the data port. After reset the port is locked. Software opens it by writing the entry key 0x87 to address 0 twice in a row. It then writes a register index to address 0 and reads or writes that register through address 1. Writing 0xAA to address 0 closes the port again.

The block holds a small set of global registers:

- a logical-device number;
- a fixed, read-only chip ID;
- four pin-multiplexing bytes that apply whatever device is selected.

Index 0x30 is an activate register kept separately for every logical device. Indices above 0x30 go out on a device-side register interface to the logical device whose number is currently selected, for example the watchdog at device 0x08.

Host reads are answered one cycle after the read strobe with a one-cycle `bus_rvalid` pulse. The host bus has no back-pressure: the port accepts a strobe in every cycle and the host must take read data in the cycle `bus_rvalid` is high. The device side is combinational. `dev_wr` and `dev_rd` are pulses in the same cycle as the host strobe, and `dev_rdata` must be valid in that cycle.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the index is 0x00, `ld_number` is 0x00, every bit of `ld_active` is 0, `pin_mux` is 0 and `bus_rvalid` is 0.
- R2: Two consecutive writes of 0x87 to address 0 open the port (`cfg_mode` high from the cycle after the second write).
- R3: Any other write (another value at address 0, or any write at address 1) that comes between the two 0x87 writes restarts the key sequence, and the port stays locked.
- R4: While the port is open, writing 0xAA to address 0 locks it.
- R5: While the port is locked, reads of either address return 0xFF, and writes to address 1 change no register and create no `dev_wr` pulse.
- R6: While the port is open, a write to address 0 (other than 0xAA) sets the index, and a read of address 0 returns the index.
- R7: Index 0x07 is a read/write byte that holds the selected logical-device number and drives `ld_number`.
- R8: Index 0x20 always reads CHIP_ID (default 0x52), and writes to it are ignored.
- R9: Indices 0x29, 0x2B, 0x2C and 0x2D are read/write bytes driven on `pin_mux` bits [7:0], [15:8], [23:16] and [31:24] respectively.
- R10: Index 0x30 is banked by `ld_number`. Bit 0 of a write sets `ld_active[ld_number]`, and a read returns that bit in bit 0 with the other bits zero. A device number at or above NUM_LD stores nothing and reads 0x00.
- R11: Indices above 0x30 are forwarded. A data write pulses `dev_wr` with `dev_index` and `dev_wdata`. A data read pulses `dev_rd`, and `dev_rdata` is returned to the host.
- R12: Every read strobe produces `bus_rvalid` exactly one cycle later, carrying the data selected in the strobe cycle.
- R13: Global indices below 0x30 that are not defined read 0x00, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | 0 = index/key port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle read-data pulse |
| cfg_mode | output | 1 | Port is open |
| ld_number | output | 8 | Selected logical device |
| ld_active | output | NUM_LD | Per-device activate bits |
| pin_mux | output | 32 | Four pin-multiplexing bytes |
| dev_wr | output | 1 | Forwarded register write pulse |
| dev_rd | output | 1 | Forwarded register read pulse |
| dev_index | output | 8 | Forwarded register index |
| dev_wdata | output | 8 | Forwarded write data |
| dev_rdata | input | 8 | Read data from the selected device |

## Verification
Writes take effect at the clock edge that samples the strobe. The bench therefore checks `cfg_mode`, `ld_number`, `ld_active` and `pin_mux` at the falling edge that follows. The forwarded strobes are combinational, so they are checked 1 ns after the inputs are driven within the strobe cycle. Read results are due exactly one cycle after the strobe. The read task pushes the expected byte into a queue at the strobe, and a monitor pops and compares it at the next falling edge on which `bus_rvalid` is high. A read that returns with nothing queued, or an expected byte still queued at the end, counts as a failure.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  typedef enum logic [1:0] {KS_LOCKED, KS_HALF, KS_OPEN} key_state_t;

  localparam logic [7:0] KEY_ENTER  = 8'h87;
  localparam logic [7:0] KEY_EXIT   = 8'hAA;
  localparam logic [7:0] IDX_LDSEL  = 8'h07;
  localparam logic [7:0] IDX_CHIPID = 8'h20;
  localparam logic [7:0] IDX_MUX0   = 8'h29;
  localparam logic [7:0] IDX_MUX1   = 8'h2B;
  localparam logic [7:0] IDX_MUX2   = 8'h2C;
  localparam logic [7:0] IDX_MUX3   = 8'h2D;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam int         MUX_BYTES  = 4;
endpackage

// File: rtl/sio_key_fsm.sv
module sio_key_fsm
  import sio_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic       open
);
  key_state_t state;
  logic       key_wr;

  assign key_wr = wr && !addr;
  assign open   = (state == KS_OPEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KS_LOCKED;
    end else begin
      case (state)
        KS_LOCKED: if (key_wr && wdata == KEY_ENTER) state <= KS_HALF;
        KS_HALF:   if (wr) state <= (key_wr && wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   if (key_wr && wdata == KEY_EXIT) state <= KS_LOCKED;
        default:   state <= KS_LOCKED;
      endcase
    end
  end

  // R2: second consecutive key write opens the port
  assert_key_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_HALF && key_wr && wdata == KEY_ENTER) |=> open);

  // R3: an intervening foreign write keeps the port locked
  assert_key_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == KS_HALF && wr && !(key_wr && wdata == KEY_ENTER)) |=> !open);

  // R4: exit key locks
  assert_exit_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (open && key_wr && wdata == KEY_EXIT) |=> !open);
endmodule

// File: rtl/sio_global_regs.sv
module sio_global_regs
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h52
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [7:0]              idx,
  input  logic [7:0]              wdata,
  output logic [7:0]              ld_num,
  output logic [MUX_BYTES*8-1:0]  mux_out,
  output logic [7:0]              rd_data
);
  localparam logic [7:0] MUX_IDX [MUX_BYTES] = '{IDX_MUX0, IDX_MUX1, IDX_MUX2, IDX_MUX3};

  logic [7:0] mux_q [MUX_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ld_num <= 8'h00;
    else if (wr_en && idx == IDX_LDSEL)  ld_num <= wdata;
  end

  for (genvar g = 0; g < MUX_BYTES; g++) begin : g_mux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          mux_q[g] <= 8'h00;
      else if (wr_en && idx == MUX_IDX[g]) mux_q[g] <= wdata;
    end
    assign mux_out[g*8 +: 8] = mux_q[g];
  end

  always_comb begin
    rd_data = 8'h00;
    if (idx == IDX_LDSEL)  rd_data = ld_num;
    if (idx == IDX_CHIPID) rd_data = CHIP_ID;
    for (int k = 0; k < MUX_BYTES; k++)
      if (idx == MUX_IDX[k]) rd_data = mux_q[k];
  end

  // R9: a mux-byte write lands in its slot
  assert_mux_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_MUX1) |=> mux_out[15:8] == $past(wdata));
endmodule

// File: rtl/sio_ld_bank.sv
module sio_ld_bank
  import sio_cfg_pkg::*;
#(
  parameter int NUM_LD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        idx,
  input  logic              act_bit,
  input  logic [7:0]        ld_num,
  output logic [NUM_LD-1:0] active,
  output logic [7:0]        rd_data
);
  localparam int LDW = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;

  logic in_range;
  assign in_range = (32'(ld_num) < NUM_LD);

  for (genvar g = 0; g < NUM_LD; g++) begin : g_dev
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active[g] <= 1'b0;
      else if (wr_en && idx == IDX_ACT && ld_num == 8'(g)) active[g] <= act_bit;
    end
  end

  assign rd_data = in_range ? {7'b0, active[ld_num[LDW-1:0]]} : 8'h00;

  // R10: writes for an unbacked device number change no activate bit
  assert_bank_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_ACT && !in_range) |=> $stable(active));
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] CHIP_ID = 8'h52,
  parameter int         NUM_LD  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              bus_rvalid,
  output logic              cfg_mode,
  output logic [7:0]        ld_number,
  output logic [NUM_LD-1:0] ld_active,
  output logic [31:0]       pin_mux,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_index,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata
);
  logic       open;
  logic [7:0] index_q;
  logic       data_wr;
  logic [7:0] glob_rd, bank_rd, rd_sel;
  logic       fwd;

  sio_key_fsm u_key (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .open(open)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= 8'h00;
    else if (open && bus_wr && !bus_addr && bus_wdata != KEY_EXIT) index_q <= bus_wdata;
  end

  assign data_wr = open && bus_wr && bus_addr;
  assign fwd     = (index_q > IDX_ACT);

  sio_global_regs #(.CHIP_ID(CHIP_ID)) u_glob (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(index_q), .wdata(bus_wdata),
    .ld_num(ld_number), .mux_out(pin_mux), .rd_data(glob_rd)
  );

  sio_ld_bank #(.NUM_LD(NUM_LD)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .idx(index_q), .act_bit(bus_wdata[0]),
    .ld_num(ld_number), .active(ld_active), .rd_data(bank_rd)
  );

  assign cfg_mode  = open;
  assign dev_wr    = data_wr && fwd;
  assign dev_rd    = open && bus_rd && bus_addr && fwd;
  assign dev_index = index_q;
  assign dev_wdata = bus_wdata;

  always_comb begin
    if (!open)               rd_sel = 8'hFF;
    else if (!bus_addr)      rd_sel = index_q;
    else if (index_q < IDX_ACT) rd_sel = glob_rd;
    else if (!fwd)           rd_sel = bank_rd;
    else                     rd_sel = dev_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_sel;
    end
  end

  // R12: one read strobe, one response a cycle later
  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_spurious_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  // R5: locked data reads give all ones
  assert_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !cfg_mode) |=> bus_rdata == 8'hFF);
  // R8: chip ID constant on read
  assert_chip_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr && cfg_mode && index_q == IDX_CHIPID) |=> bus_rdata == CHIP_ID);
  // R11: forwarding only when open
  assert_fwd_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> cfg_mode);
endmodule

// File: tb/sio_cfg_port_tb_top.sv
module sio_cfg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic        bus_rvalid, cfg_mode, dev_wr, dev_rd;
  logic [7:0]  ld_number, dev_index, dev_wdata, dev_rdata;
  logic [15:0] ld_active;
  logic [31:0] pin_mux;

  int checks = 0, fails = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  assign dev_rdata = dev_index ^ 8'h5A;

  sio_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .cfg_mode(cfg_mode), .ld_number(ld_number), .ld_active(ld_active), .pin_mux(pin_mux),
    .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_index(dev_index), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx); wr(1'b1, d);
  endtask

  task automatic reg_rd(input logic [7:0] idx, input logic [7:0] exp, input string tag);
    wr(1'b0, idx); rd(1'b1, exp, tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: unexpected read response %h", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk({24'h0, bus_rdata}, {24'h0, e}, t);
      end
    end
  end

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({31'h0, cfg_mode}, 32'h0, "R1 cfg_mode");
    chk({24'h0, ld_number}, 32'h0, "R1 ld_number");
    chk({16'h0, ld_active}, 32'h0, "R1 ld_active");
    chk(pin_mux, 32'h0, "R1 pin_mux");
    chk({31'h0, bus_rvalid}, 32'h0, "R1 rvalid");
    // R5 locked
    rd(1'b1, 8'hFF, "R5 locked data read");
    rd(1'b0, 8'hFF, "R5 locked index read");
    wr(1'b0, 8'h29);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h33;
    #1 chk({31'h0, dev_wr}, 32'h0, "R5 no dev_wr when locked");
    @(negedge clk); bus_wr = 1'b0;
    chk(pin_mux, 32'h0, "R5 locked write ignored");
    // R3 key restarts
    wr(1'b0, 8'h87); wr(1'b1, 8'h00); wr(1'b0, 8'h87);
    chk({31'h0, cfg_mode}, 32'h0, "R3 data write between keys");
    wr(1'b0, 8'h00);
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    chk({31'h0, cfg_mode}, 32'h0, "R3 other value between keys");
    wr(1'b0, 8'h00);
    chk({31'h0, cfg_mode}, 32'h0, "R3 still locked");
    // R2 unlock
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    chk({31'h0, cfg_mode}, 32'h1, "R2 unlocked");
    // R6 index
    wr(1'b0, 8'h2B);
    rd(1'b0, 8'h2B, "R6 index readback");
    // R9 mux
    wr(1'b1, 8'hC3);
    chk(pin_mux, 32'h0000C300, "R9 mux byte 0x2B");
    rd(1'b1, 8'hC3, "R9 mux read");
    reg_wr(8'h29, 8'h11); reg_wr(8'h2C, 8'h22); reg_wr(8'h2D, 8'h44);
    chk(pin_mux, 32'h4422C311, "R9 all mux bytes");
    // R8 chip id
    reg_rd(8'h20, 8'h52, "R8 chip id");
    wr(1'b1, 8'h99);
    rd(1'b1, 8'h52, "R8 chip id after write");
    // R13 undefined global
    reg_wr(8'h25, 8'h77);
    rd(1'b1, 8'h00, "R13 undefined global");
    // R7 device select
    reg_wr(8'h07, 8'h08);
    chk({24'h0, ld_number}, 32'h8, "R7 ld_number");
    rd(1'b1, 8'h08, "R7 ld readback");
    // R10 banked activate
    reg_wr(8'h30, 8'h01);
    chk({16'h0, ld_active}, 32'h0100, "R10 activate dev 8");
    rd(1'b1, 8'h01, "R10 read dev 8");
    reg_wr(8'h07, 8'h03);
    reg_rd(8'h30, 8'h00, "R10 dev 3 independent");
    wr(1'b1, 8'hFF);
    chk({16'h0, ld_active}, 32'h0108, "R10 activate dev 3");
    rd(1'b1, 8'h01, "R10 read dev 3 bit0 only");
    reg_wr(8'h07, 8'h20);
    reg_wr(8'h30, 8'h01);
    chk({16'h0, ld_active}, 32'h0108, "R10 out of range write");
    rd(1'b1, 8'h00, "R10 out of range read");
    // R11 forwarding
    reg_wr(8'h07, 8'h08);
    wr(1'b0, 8'hF5);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h0C;
    #1 chk({dev_wr, 7'h0, dev_index, dev_wdata, ld_number}, {1'b1, 7'h0, 24'hF50C08}, "R11 forwarded write");
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 1'b1;
    exp_q.push_back(8'hAF); tag_q.push_back("R11 forwarded read data");
    #1 chk({31'h0, dev_rd}, 32'h1, "R11 dev_rd pulse");
    @(negedge clk); bus_rd = 1'b0;
    // R4 lock
    wr(1'b0, 8'hAA);
    chk({31'h0, cfg_mode}, 32'h0, "R4 locked by exit key");
    rd(1'b1, 8'hFF, "R4 data read after lock");
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 8'h77;
    #1 chk({31'h0, dev_wr}, 32'h0, "R5 no forward after lock");
    @(negedge clk); bus_wr = 1'b0;
    // re-open, state retained
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    reg_rd(8'h2B, 8'hC3, "R5 registers kept across lock");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL R12: actual %0d pending expected 0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule